// File: doc/BRIEF.md
# Time-Slot Interchange Data Memory

This block is the storage core of a time-division-multiplexed switch. A frame is a run of channels, and each channel occupies a timeslot of four clock cycles. In every timeslot the block captures one 16-bit word from the input bus and stores it at the memory location of the current input channel. The location comes from a channel counter that steps once per timeslot. In the same timeslot it fetches one stored word from a location named on the external address bus and presents it on the output bus for the rest of the slot.

A frame pulse restarts the channel counter and the slot sequencer, which aligns the block to the frame boundary of the surrounding system. Without a pulse the counter wraps by itself at the end of the frame. Inside a slot, the fetch and the store of the previous slot's word share one edge, and the fetch sees the old content. As a result, a word switched to the same channel or to the next channel is delivered one frame later. A word switched two or more channels forward arrives within the frame.

The slot sequencer has four named states that always run in this order: `PH_ADDR` (phase 0), `PH_READ` (phase 1), `PH_IDLE` (phase 2) and `PH_LATCH` (phase 3). Transitions are `PH_ADDR->PH_READ`, `PH_READ->PH_IDLE`, `PH_IDLE->PH_LATCH` and `PH_LATCH->PH_ADDR`. There is also a restart transition from any state to `PH_ADDR` when the frame pulse is sampled high.

Top module: `tsi_data_memory`

## Requirements
- R1: A timeslot lasts exactly 4 clock cycles, with phases in the fixed order 0 (address), 1 (read), 2 (idle), 3 (latch). After synchronous reset is released, the first cycle is phase 0 of channel 0.
- R2: The channel counter advances by one at the end of each phase-3 cycle. It wraps from CHANNELS-1 to 0 without any frame pulse.
- R3: When `frame_sync` is high at a rising edge, the next cycle is phase 0 of channel 0, whatever the phase and channel were.
- R4: `din` is sampled at the end of the phase-3 cycle. It is written at the end of the following phase-0 cycle, to the location of the channel that was current when it was sampled, even if a frame pulse restarted the counter in between.
- R5: `rd_addr` is sampled at the end of the phase-0 cycle, and the memory is read at that edge. Only the low log2(CHANNELS) bits select the location and the upper bits have no effect. A write on the same edge is not visible to that read.
- R6: `dout` is loaded at the end of the phase-1 cycle and holds its value until the next phase-1 edge.
- R7: A word from input channel N read in output channel N, or in output channel N+1 (modulo the frame), reaches `dout` one frame after it was captured.
- R8: A word from input channel N read in output channel N+2 or later in the same frame reaches `dout` in that frame.
- R9: A synchronous reset sets `dout` to 0 and returns the phase and channel counters to 0. Memory contents stay undefined until written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Frame pulse; restarts the slot sequencer at channel 0 |
| din | input | DATA_W (16) | Input channel word, sampled in phase 3 |
| rd_addr | input | ADDR_W (16) | Read location for the current output slot, sampled in phase 0 |
| dout | output | DATA_W (16) | Output channel word, loaded in phase 1 and held |

## Verification
On every cycle the assertions check the slot sequencing: the phase steps by one, the channel counter holds except after phase 3 and stays within the frame, and a frame pulse restarts at phase 0 of channel 0. They also check that writes occur only in phase 0, that `dout` moves only after a read phase, and that reset clears state. The one-frame versus one-channel delay, the masking of the upper address bits, and a pending word landing at its captured channel across a mid-frame restart all depend on data values. Only the bench's sweep over every input-to-output channel distance, and its directed restart scenario, can show these.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_READ  = 2'd1,
        PH_IDLE  = 2'd2,
        PH_LATCH = 2'd3
    } slot_phase_e;
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tsi_pkg::*;
#(
    parameter int CHANNELS = 1024,
    parameter int CH_W     = $clog2(CHANNELS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_sync,
    output slot_phase_e     phase,
    output logic [CH_W-1:0] chan,
    output logic            addr_stb,
    output logic            read_stb,
    output logic            latch_stb
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(CHANNELS - 1);

    slot_phase_e     state_q, state_d;
    logic [CH_W-1:0] chan_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ADDR:  state_d = PH_READ;
            PH_READ:  state_d = PH_IDLE;
            PH_IDLE:  state_d = PH_LATCH;
            PH_LATCH: state_d = PH_ADDR;
        endcase
        if (frame_sync) state_d = PH_ADDR;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_ADDR;
        else     state_q <= state_d;
    end

    // channel counter: steps at slot end, wraps, restarts on frame pulse
    always_ff @(posedge clk) begin
        if (rst || frame_sync)      chan_q <= '0;
        else if (state_q == PH_LATCH)
            chan_q <= (chan_q == LAST_CH) ? '0 : chan_q + 1'b1;
    end

    // per-state strobes
    always_comb begin
        addr_stb  = 1'b0;
        read_stb  = 1'b0;
        latch_stb = 1'b0;
        unique case (state_q)
            PH_ADDR:  addr_stb  = 1'b1;
            PH_READ:  read_stb  = 1'b1;
            PH_IDLE:  ;
            PH_LATCH: latch_stb = 1'b1;
        endcase
    end

    assign phase = state_q;
    assign chan  = chan_q;
endmodule

// File: rtl/tsi_input_stage.sv
module tsi_input_stage #(
    parameter int DATA_W = 16,
    parameter int CH_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_stb,
    input  logic              addr_stb,
    input  logic [CH_W-1:0]   chan,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] word_q;
    logic [CH_W-1:0]   slot_q;
    logic              pend_q;

    // hold the captured word together with its own channel number
    always_ff @(posedge clk) begin
        if (latch_stb) begin
            word_q <= din;
            slot_q <= chan;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (latch_stb) pend_q <= 1'b1;
        else if (addr_stb)  pend_q <= 1'b0;
    end

    assign wr_en   = addr_stb & pend_q;
    assign wr_addr = slot_q;
    assign wr_data = word_q;
endmodule

// File: rtl/tsi_store.sv
module tsi_store #(
    parameter int DATA_W = 16,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    // read returns the content before a same-edge write
    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= cells[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/tsi_data_memory.sv
module tsi_data_memory
    import tsi_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int CHANNELS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dout
);
    localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

    slot_phase_e       phase_w;
    logic [CH_W-1:0]   chan_w;
    logic              addr_stb, read_stb, latch_stb;
    logic              we_w;
    logic [CH_W-1:0]   wa_w;
    logic [DATA_W-1:0] wd_w;
    logic [DATA_W-1:0] rdata_w;
    logic [DATA_W-1:0] dout_q;
    logic [CH_W-1:0]   sel_addr;

    assign sel_addr = rd_addr[CH_W-1:0];

    generate
        if (ADDR_W > CH_W) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^rd_addr[ADDR_W-1:CH_W];
        end
    endgenerate

    tsi_slot_timer #(.CHANNELS(CHANNELS), .CH_W(CH_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .frame_sync(frame_sync),
        .phase     (phase_w),
        .chan      (chan_w),
        .addr_stb  (addr_stb),
        .read_stb  (read_stb),
        .latch_stb (latch_stb)
    );

    tsi_input_stage #(.DATA_W(DATA_W), .CH_W(CH_W)) u_in (
        .clk      (clk),
        .rst      (rst),
        .latch_stb(latch_stb),
        .addr_stb (addr_stb),
        .chan     (chan_w),
        .din      (din),
        .wr_en    (we_w),
        .wr_addr  (wa_w),
        .wr_data  (wd_w)
    );

    tsi_store #(.DATA_W(DATA_W), .AW(CH_W)) u_mem (
        .clk    (clk),
        .wr_en  (we_w),
        .wr_addr(wa_w),
        .wr_data(wd_w),
        .rd_en  (addr_stb),
        .rd_addr(sel_addr),
        .rd_data(rdata_w)
    );

    always_ff @(posedge clk) begin
        if (rst)           dout_q <= '0;
        else if (read_stb) dout_q <= rdata_w;
    end

    assign dout = dout_q;
endmodule

// File: rtl/tsi_data_memory_chk.sv
module tsi_data_memory_chk #(
    parameter int DATA_W   = 16,
    parameter int CHANNELS = 1024,
    parameter int CH_W     = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_sync,
    input logic [DATA_W-1:0] dout,
    input logic [1:0]        phase,
    input logic [CH_W-1:0]   chan,
    input logic              mem_we
);
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> phase == 2'($past(phase) + 2'd1));

    a_r3_frame_restart: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (phase == 2'd0 && chan == '0));

    a_r2_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (!frame_sync && phase != 2'd3) |=> $stable(chan));

    always_ff @(posedge clk) begin
        if (!rst) begin
            a_r2_chan_range: assert (int'(chan) < CHANNELS);
        end
    end

    a_r4_write_phase: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> phase == 2'd0);

    a_r6_dout_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd1) |=> $stable(dout));

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (dout == '0 && chan == '0 && phase == 2'd0));
endmodule

bind tsi_data_memory tsi_data_memory_chk #(
    .DATA_W  (DATA_W),
    .CHANNELS(CHANNELS),
    .CH_W    (CH_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_sync(frame_sync),
    .dout      (dout),
    .phase     (phase_w),
    .chan      (chan_w),
    .mem_we    (we_w)
);

// File: tb/tsi_data_memory_tb.sv
module tsi_data_memory_tb;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_sync;
    logic [15:0] din;
    logic [15:0] rd_addr;
    logic [15:0] dout;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    tsi_data_memory #(.DATA_W(16), .ADDR_W(16), .CHANNELS(NCH)) u_dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync),
        .din(din), .rd_addr(rd_addr), .dout(dout)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] word_of(int g);
        return 16'((g * 40503 + 4660) & 16'hFFFF);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one timeslot; entered and left at a falling edge inside phase 0
    task automatic run_slot(input logic [15:0] d, input logic [15:0] a,
                            input bit fs_last,
                            output logic [15:0] o2, output logic [15:0] o3);
        for (int p = 0; p < 4; p++) begin
            din        = d;
            rd_addr    = a;
            frame_sync = fs_last && (p == 3);
            if (p == 2) o2 = dout;
            if (p == 3) o3 = dout;
            @(posedge clk);
            @(negedge clk);
        end
        frame_sync = 1'b0;
    endtask

    initial begin
        logic [15:0] o2, o3;
        rst = 1'b1; frame_sync = 1'b0; din = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 dout after reset", dout, 16'h0000);
        rst = 1'b0;

        // sweep every input-to-output distance, no frame pulse (R1, R2 wrap)
        for (int f = 0; f < 10; f++) begin
            for (int c = 0; c < NCH; c++) begin
                int g, d, a, t, k, gin;
                logic [15:0] addr;
                g = f * NCH + c;
                d = f % NCH;
                a = (c - d + NCH) % NCH;
                addr = 16'(((g * 37) << 3) | a); // R5 upper bits vary
                run_slot(word_of(g), addr, 1'b0, o2, o3);
                t = g - 2;
                if (t >= 0) begin
                    k = ((t - a) % NCH + NCH) % NCH;
                    gin = t - k;
                    if (gin >= 0) begin
                        if (d <= 1) check("R7 one-frame delay (R5 R2)", o2, word_of(gin));
                        else        check("R8 one-channel delay (R5 R2)", o2, word_of(gin));
                        check("R6 dout held in phase 3", o3, o2);
                    end
                end
            end
        end

        // mid-run reset, then restart by frame pulse after channel 4
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 dout cleared by reset", dout, 16'h0000);
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 5; c++) begin
            run_slot(16'hA000 + 16'(c), 16'h0000, c == 4, o2, o3);
            if (c == 2) check("R9 counter restarted at channel 0 (R4)", o2, 16'hA000);
        end
        // new frame: channel 0 again
        run_slot(16'hB000, 16'h0003, 1'b0, o2, o3);
        check("R4 write of old channel 3", o2, 16'hA003);
        run_slot(16'hB001, 16'hFF04, 1'b0, o2, o3);
        check("R4 pending word kept its channel across pulse", o2, 16'hA004);
        run_slot(16'hB002, 16'h0000, 1'b0, o2, o3);
        check("R3 frame pulse restarted channel count", o2, 16'hB000);
        run_slot(16'hB003, 16'h0001, 1'b0, o2, o3);
        check("R3 second channel of new frame", o2, 16'hB001);
        run_slot(16'hB004, 16'h0003, 1'b0, o2, o3);
        check("R7 same-slot read sees previous content", o2, 16'hA003);
        check("R6 dout stable", o3, o2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule